// File: doc/BRIEF.md
# Registered Multiplier with Rounding and Split Product Halves

This block multiplies two 8-bit operands and presents the 16-bit product as two 8-bit halves, each with its own output enable, so that both halves can be read in turn over a shared byte-wide path. Operand A, operand B and the product each sit in their own register, and each register has its own load strobe. The operands can therefore arrive at different times, and a product can be frozen while new operands are staged. All three registers share one clock.

A build-time parameter selects how the operands are read: as two's complement or as unsigned magnitudes. A round request is captured together with the operands, and adds one at the top bit of the lower half. Discarding the lower half then leaves a correctly rounded 8-bit result. The capture rule for the round request depends on the selected format. In two's complement format the upper half carries the sign followed by the next seven significant bits, and the lower half repeats the sign above the seven least significant bits.

Each half has an active-low enable. A disabled half drives zero and lowers its valid flag, so a bus multiplexer downstream can merge it with other sources.

Top module: `round_split_mult`

## Requirements
- R1: Operand A is loaded from `op_a` only at a clock edge where `ld_a` is 1, and operand B from `op_b` only at an edge where `ld_b` is 1. At all other edges each keeps its value, whatever the data inputs do.
- R2: The product register loads at an edge where `ld_r` is 1 and holds its value at every other edge.
- R3: In two's complement format (`FMT = FMT_TWOS`) the round request `rnd` is captured at every edge where `ld_a` or `ld_b` is 1.
- R4: In unsigned format (`FMT = FMT_UNS`) `rnd` is captured only at edges where `ld_a` is 1. A `ld_b`-only load leaves the captured round bit unchanged.
- R5: In two's complement format, with operands read as signed and the captured round bit r, let t be bits 14..0 of (A*B + 128*r) in two's complement. Then `prod_hi` = t[14:7] and `prod_lo` = {t[14], t[6:0]}, so bit 7 of both halves carries the sign.
- R6: In unsigned format, let s = A*B + 128*r. Then `prod_hi` = s[15:8] and `prod_lo` = s[7:0].
- R7: Two's complement results wrap and are not saturated. For -128 times -128, both halves read 8'h80 without rounding; with rounding the halves read 8'h81 (upper) and 8'h80 (lower).
- R8: `oe_hi_n` = 1 forces `prod_hi` to 0 and `hi_vld` to 0. `oe_lo_n` = 1 does the same for `prod_lo` and `lo_vld`. The two enables act independently, and with an enable at 0 its half shows the stored value and its valid flag is 1.
- R9: A clock edge with `rst_n` = 0 clears both operands, the round bit and the product register, so that both enabled halves read 0.
- R10: A product load at the same edge as an operand load uses the operands and round bit held before that edge. The new operands appear only at the next product load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 8 | Operand A data |
| op_b | input | 8 | Operand B data |
| rnd | input | 1 | Round request |
| ld_a | input | 1 | Load strobe for operand A |
| ld_b | input | 1 | Load strobe for operand B |
| ld_r | input | 1 | Load strobe for the product register |
| oe_hi_n | input | 1 | Active-low enable of the upper half |
| oe_lo_n | input | 1 | Active-low enable of the lower half |
| prod_hi | output | 8 | Upper product half, zero when disabled |
| prod_lo | output | 8 | Lower product half, zero when disabled |
| hi_vld | output | 1 | Upper half is enabled |
| lo_vld | output | 1 | Lower half is enabled |

## Verification
An operand load and a product load can fall on the same edge. This is the normal streaming mode, and it also exposes any bypass from the operand inputs into the product. The bench raises all three strobes at once with new operands and expects the product of the previously held pair, then the product of the new pair after one more product load. The exhaustive sweeps of every operand pair, with and without rounding and in both formats, run in this overlapped mode throughout. Each result is compared against a reference computed two edges earlier.

// File: rtl/rsm_pkg.sv
// Shared types for the rounding split multiplier.
// Assumes: the format is fixed at elaboration and never changes at run time.
package rsm_pkg;
    typedef enum logic {
        FMT_UNS  = 1'b0,
        FMT_TWOS = 1'b1
    } fmt_e;
endpackage

// File: rtl/rsm_capture.sv
// Enabled register with synchronous active-low clear.
// Assumes: en is a single-cycle or level load strobe in the clk domain.
module rsm_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load d when enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end

    // R1
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
endmodule

// File: rtl/rsm_format.sv
// Combinational multiply, rounding addition and mapping into two halves.
// Assumes: the round weight sits at bit W-1. In two's complement format
// the sum is cut to 2W-1 bits and the sign is copied into bit W-1.
module rsm_format
    import rsm_pkg::*;
#(
    parameter int   W   = 8,
    parameter fmt_e FMT = FMT_TWOS
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           rnd,
    output logic [2*W-1:0] res
);
    localparam int PW = 2 * W;

    logic [PW-1:0] rnd_term;

    // Place the round request at the top bit of the lower half.
    always_comb begin
        rnd_term        = '0;
        rnd_term[W-1]   = rnd;
    end

    generate
        if (FMT == FMT_TWOS) begin : g_twos
            logic signed [PW-1:0] prod;
            logic        [PW-1:0] sum;
            assign prod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
            assign sum  = prod + rnd_term;
            assign res  = {sum[PW-2:W-1], sum[PW-2], sum[W-2:0]};
        end else begin : g_uns
            assign res = ({{W{1'b0}}, a} * {{W{1'b0}}, b}) + rnd_term;
        end
    endgenerate
endmodule

// File: rtl/rsm_outgate.sv
// Product register plus per-half enable gating with valid flags.
// Assumes: enables are active low; a disabled half drives zero.
module rsm_outgate #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_r,
    input  logic [2*W-1:0] d,
    input  logic           oe_hi_n,
    input  logic           oe_lo_n,
    output logic [W-1:0]   prod_hi,
    output logic [W-1:0]   prod_lo,
    output logic           hi_vld,
    output logic           lo_vld
);
    logic [2*W-1:0] res_q;

    // Hold the product until the next load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    res_q <= '0;
        else if (ld_r) res_q <= d;
    end

    // Gate each half by its own enable.
    always_comb begin
        hi_vld  = !oe_hi_n;
        lo_vld  = !oe_lo_n;
        prod_hi = hi_vld ? res_q[2*W-1:W] : '0;
        prod_lo = lo_vld ? res_q[W-1:0]   : '0;
    end

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_r |=> $stable(res_q));
    // R8
    hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_hi_n |-> (!hi_vld && prod_hi == '0));
    // R8
    lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_lo_n |-> (!lo_vld && prod_lo == '0));
endmodule

// File: rtl/round_split_mult.sv
// Top level: operand and round capture, product formatting, product register.
// Assumes: one clock with separate load strobes for A, B and the product.
module round_split_mult
    import rsm_pkg::*;
#(
    parameter int   W   = 8,
    parameter fmt_e FMT = FMT_TWOS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         rnd,
    input  logic         ld_a,
    input  logic         ld_b,
    input  logic         ld_r,
    input  logic         oe_hi_n,
    input  logic         oe_lo_n,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         hi_vld,
    output logic         lo_vld
);
    logic [W-1:0]   a_q, b_q;
    logic           rnd_q, rnd_en;
    logic [2*W-1:0] fmt_res;

    // The format picks which loads capture the round request.
    generate
        if (FMT == FMT_TWOS) begin : g_rnd_twos
            assign rnd_en = ld_a | ld_b;
        end else begin : g_rnd_uns
            assign rnd_en = ld_a;
        end
    endgenerate

    rsm_capture #(.W(W)) u_cap_a (
        .clk(clk), .rst_n(rst_n), .en(ld_a), .d(op_a), .q(a_q));
    rsm_capture #(.W(W)) u_cap_b (
        .clk(clk), .rst_n(rst_n), .en(ld_b), .d(op_b), .q(b_q));
    rsm_capture #(.W(1)) u_cap_rnd (
        .clk(clk), .rst_n(rst_n), .en(rnd_en), .d(rnd), .q(rnd_q));

    rsm_format #(.W(W), .FMT(FMT)) u_fmt (
        .a(a_q), .b(b_q), .rnd(rnd_q), .res(fmt_res));

    rsm_outgate #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .ld_r(ld_r), .d(fmt_res),
        .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
        .prod_hi(prod_hi), .prod_lo(prod_lo),
        .hi_vld(hi_vld), .lo_vld(lo_vld));

    generate
        if (FMT == FMT_TWOS) begin : g_chk_twos
            // R3
            rnd_any_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ld_a || ld_b) |=> (rnd_q == $past(rnd)));
            // R5
            sign_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!oe_hi_n && !oe_lo_n) |-> (prod_hi[W-1] == prod_lo[W-1]));
        end else begin : g_chk_uns
            // R4
            rnd_b_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ld_b && !ld_a) |=> $stable(rnd_q));
            // R6
            round_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ld_r && rnd_q) |=> ({u_out.res_q} >= (2*W)'(1 << (W-1))));
        end
    endgenerate
endmodule

// File: tb/round_split_mult_tb.sv
`timescale 1ns/1ps
module round_split_mult_tb;
    import rsm_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0, op_b = '0;
    logic       rnd = 1'b0, ld_a = 1'b0, ld_b = 1'b0, ld_r = 1'b0;
    logic       oe_hi_n = 1'b0, oe_lo_n = 1'b0;
    logic [7:0] s_hi, s_lo, u_hi, u_lo;
    logic       s_hv, s_lv, u_hv, u_lv;
    int         n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    round_split_mult #(.W(8), .FMT(FMT_TWOS)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .rnd(rnd),
        .ld_a(ld_a), .ld_b(ld_b), .ld_r(ld_r), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
        .prod_hi(s_hi), .prod_lo(s_lo), .hi_vld(s_hv), .lo_vld(s_lv));

    round_split_mult #(.W(8), .FMT(FMT_UNS)) u_dut_uns (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .rnd(rnd),
        .ld_a(ld_a), .ld_b(ld_b), .ld_r(ld_r), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
        .prod_hi(u_hi), .prod_lo(u_lo), .hi_vld(u_hv), .lo_vld(u_lv));

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog got %0d cycles exp < 190000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [15:0] ref_s(input logic [7:0] a, input logic [7:0] b, input logic r);
        int pa, pb, v;
        logic [31:0] vv;
        pa = $signed(a); pb = $signed(b);
        v  = pa * pb + (r ? 128 : 0);
        vv = v;
        return {vv[14:7], vv[14], vv[6:0]};
    endfunction

    function automatic logic [15:0] ref_u(input logic [7:0] a, input logic [7:0] b, input logic r);
        int v;
        logic [31:0] vv;
        v  = int'(a) * int'(b) + (r ? 128 : 0);
        vv = v;
        return vv[15:0];
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // One negedge-driven cycle of strobes, then strobes cleared at the next negedge.
    task automatic pulse(input logic [7:0] a, input logic [7:0] b, input logic r,
                         input logic la, input logic lb, input logic lr);
        @(negedge clk);
        op_a = a; op_b = b; rnd = r; ld_a = la; ld_b = lb; ld_r = lr;
        @(negedge clk);
        ld_a = 1'b0; ld_b = 1'b0; ld_r = 1'b0;
    endtask

    task automatic load_and_show(input logic [7:0] a, input logic [7:0] b, input logic r);
        pulse(a, b, r, 1'b1, 1'b1, 1'b0);
        pulse(a, b, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reset_idle;
        chk("R9 signed after reset",   {s_hi, s_lo}, 16'h0000);
        chk("R9 unsigned after reset", {u_hi, u_lo}, 16'h0000);
    endtask

    task automatic t_basic;
        load_and_show(8'h05, 8'hFD, 1'b0);
        chk("R5 5 x -3",  {s_hi, s_lo}, ref_s(8'h05, 8'hFD, 1'b0));
        chk("R6 5 x 253", {u_hi, u_lo}, ref_u(8'h05, 8'hFD, 1'b0));
        load_and_show(8'h9C, 8'h7F, 1'b1);
        chk("R5 -100 x 127 rounded", {s_hi, s_lo}, ref_s(8'h9C, 8'h7F, 1'b1));
        chk("R6 156 x 127 rounded",  {u_hi, u_lo}, ref_u(8'h9C, 8'h7F, 1'b1));
    endtask

    task automatic t_reset_clear;
        load_and_show(8'h33, 8'h44, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R9 signed cleared",   {s_hi, s_lo}, 16'h0000);
        chk("R9 unsigned cleared", {u_hi, u_lo}, 16'h0000);
        pulse(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 operands and round cleared", {u_hi, u_lo}, 16'h0000);
    endtask

    task automatic t_indep_loads;
        pulse(8'h03, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        pulse(8'h00, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0);
        pulse(8'h64, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0);
        pulse(8'h64, 8'h04, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 A ignores op_a without ld_a", {u_hi, u_lo}, 16'd12);
        pulse(8'h64, 8'h09, 1'b0, 1'b1, 1'b0, 1'b0);
        pulse(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 B ignores op_b without ld_b", {u_hi, u_lo}, 16'd400);
    endtask

    task automatic t_round_rule;
        pulse(8'h07, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        pulse(8'h00, 8'h09, 1'b1, 1'b0, 1'b1, 1'b0);
        pulse(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3 round taken on B load",   {s_hi, s_lo}, ref_s(8'h07, 8'h09, 1'b1));
        chk("R4 round ignored on B load", {u_hi, u_lo}, ref_u(8'h07, 8'h09, 1'b0));
        pulse(8'h07, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        pulse(8'h00, 8'h09, 1'b0, 1'b0, 1'b1, 1'b0);
        pulse(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R3 round cleared by B load", {s_hi, s_lo}, ref_s(8'h07, 8'h09, 1'b0));
        chk("R4 round kept after B load", {u_hi, u_lo}, ref_u(8'h07, 8'h09, 1'b1));
    endtask

    task automatic t_hold;
        load_and_show(8'h11, 8'h22, 1'b0);
        pulse(8'hEE, 8'hDD, 1'b1, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 signed held",   {s_hi, s_lo}, ref_s(8'h11, 8'h22, 1'b0));
        chk("R2 unsigned held", {u_hi, u_lo}, ref_u(8'h11, 8'h22, 1'b0));
    endtask

    task automatic t_same_edge;
        load_and_show(8'h0A, 8'h0B, 1'b0);
        pulse(8'hC8, 8'h05, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R10 old pair on shared edge s", {s_hi, s_lo}, ref_s(8'h0A, 8'h0B, 1'b0));
        chk("R10 old pair on shared edge u", {u_hi, u_lo}, ref_u(8'h0A, 8'h0B, 1'b0));
        pulse(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 new pair next load s", {s_hi, s_lo}, ref_s(8'hC8, 8'h05, 1'b1));
        chk("R10 new pair next load u", {u_hi, u_lo}, ref_u(8'hC8, 8'h05, 1'b1));
    endtask

    task automatic t_wrap;
        load_and_show(8'h80, 8'h80, 1'b0);
        chk("R7 -128 x -128", {s_hi, s_lo}, 16'h8080);
        chk("R6 128 x 128",   {u_hi, u_lo}, 16'h4000);
        load_and_show(8'h80, 8'h80, 1'b1);
        chk("R7 -128 x -128 rounded", {s_hi, s_lo}, 16'h8180);
        chk("R6 128 x 128 rounded",   {u_hi, u_lo}, 16'h4080);
    endtask

    task automatic t_enables;
        load_and_show(8'hFF, 8'hFF, 1'b0);
        @(negedge clk); oe_hi_n = 1'b1; oe_lo_n = 1'b0;
        #1;
        chk("R8 upper off", {s_hi, 6'b0, s_hv, s_lv}, 16'h0001);
        chk("R8 lower on",  {u_lo, 6'b0, u_hv, u_lv}, {ref_u(8'hFF, 8'hFF, 1'b0) & 16'h00FF, 8'h00} | 16'h0001);
        @(negedge clk); oe_hi_n = 1'b0; oe_lo_n = 1'b1;
        #1;
        chk("R8 lower off", {s_lo, 6'b0, s_hv, s_lv}, 16'h0002);
        chk("R8 upper on",  {u_hi, 6'b0, u_hv, u_lv}, (ref_u(8'hFF, 8'hFF, 1'b0) & 16'hFF00) | 16'h0002);
        @(negedge clk); oe_hi_n = 1'b1; oe_lo_n = 1'b1;
        #1;
        chk("R8 both off", {u_hi, u_lo}, 16'h0000);
        @(negedge clk); oe_hi_n = 1'b0; oe_lo_n = 1'b0;
    endtask

    // Stream every operand pair; each result appears two negedges after its drive.
    task automatic t_sweep(input logic r);
        logic [15:0] hs0 = '0, hs1 = '0, hu0 = '0, hu1 = '0;
        for (int n = 0; n < 65538; n++) begin
            @(negedge clk);
            if (n >= 2) begin
                chk(r ? "R5 sweep rounded" : "R5 sweep", {s_hi, s_lo}, hs1);
                chk(r ? "R6 sweep rounded" : "R6 sweep", {u_hi, u_lo}, hu1);
            end
            hs1 = hs0; hu1 = hu0;
            if (n < 65536) begin
                op_a = n[15:8]; op_b = n[7:0]; rnd = r;
                ld_a = 1'b1; ld_b = 1'b1; ld_r = 1'b1;
                hs0 = ref_s(n[15:8], n[7:0], r);
                hu0 = ref_u(n[15:8], n[7:0], r);
            end else begin
                ld_a = 1'b0; ld_b = 1'b0; ld_r = 1'b1;
            end
        end
        @(negedge clk);
        ld_r = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_idle();
        t_basic();
        t_reset_clear();
        t_indep_loads();
        t_round_rule();
        t_hold();
        t_same_edge();
        t_wrap();
        t_enables();
        t_sweep(1'b0);
        t_sweep(1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule